// File: doc/BRIEF.md
# Privilege-Gated Status Word Register

This block holds a 32-bit processor status word. The word carries four arithmetic flags (carry, zero, sign, overflow), an interrupt-enable bit, a stack-select bit, a processor-mode bit and a 4-bit interrupt priority level. All other bit positions are reserved. The register has one full-word write port with a qualifier that marks the write as a return-from-interrupt. It also has a clear pulse, which interrupt entry asserts. The packed word is always presented at the output so that it can be saved.

Which fields a write may change depends on the processor mode held in the register itself. In supervisor mode a write may alter the control fields. In user mode it may alter only the flags. The mode bit changes only through a return-from-interrupt write issued in supervisor mode, or through the clear pulse.

Top module: `psw_status_reg`

## Requirements
- R1: After reset the word reads 0x0000_0000, which is supervisor mode with interrupts disabled.
- R2: Flags sit at C=bit0, Z=bit1, S=bit2, O=bit3. Every accepted write loads them from the written word, in either mode.
- R3: In supervisor mode (bit20 = 0), a write loads the priority level (bits 27:24), the stack-select bit (bit17) and the interrupt-enable bit (bit16) from the written word.
- R4: In user mode (bit20 = 1), a write leaves the priority level, stack-select, interrupt-enable and mode bits unchanged.
- R5: The mode bit (bit20) changes through a write only when the return-from-interrupt qualifier is high and the current mode is supervisor. A plain write never changes it.
- R6: A clear pulse forces the mode, interrupt-enable and stack-select bits to 0. It leaves the priority level and the flags as they were.
- R7: When a write and a clear pulse fall in the same cycle, the three bits the clear affects end at 0. The flags and the priority level follow the write rules.
- R8: Reserved positions (all bits other than 3:0, 16, 17, 20 and 27:24) always read 0.
- R9: A write or clear takes effect one clock later. In a cycle with neither, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Full-word write strobe |
| wr_rti | input | 1 | Marks the write as a return-from-interrupt |
| wr_data | input | 32 | Word to be written |
| entry_clr | input | 1 | Interrupt-entry clear pulse |
| psw_word | output | 32 | Packed status word |
| cur_ipl | output | 4 | Current priority level |
| user_mode | output | 1 | Mode bit, 1 = user |
| int_en | output | 1 | Interrupt-enable bit |
| stack_sel | output | 1 | Stack-select bit |

## Verification
Every field is registered, so each result of a write or clear is due exactly one rising edge after the strobes are sampled. The driver sets the strobes on a falling edge. It waits for the next rising edge, computes the expected word from the field rules, and queues that word. The monitor pops the entry on the following falling edge, so each comparison lands half a cycle after the register has settled. Idle cycles are queued the same way, which shows that the word holds its value when nothing is strobed.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int WORD_W   = 32;
  localparam int NFLAGS   = 4;
  localparam int IPL_W    = 4;
  localparam int POS_I    = 16;
  localparam int POS_U    = 17;
  localparam int POS_PM   = 20;
  localparam int IPL_LSB  = 24;
  localparam int IPL_MSB  = IPL_LSB + IPL_W - 1;

  typedef struct packed {
    logic [IPL_W-1:0]  ipl;
    logic              pm;
    logic              u;
    logic              i;
    logic [NFLAGS-1:0] flags;
  } psw_fields_t;

  function automatic logic [WORD_W-1:0] psw_pack(input psw_fields_t f);
    logic [WORD_W-1:0] w;
    w = '0;
    w[NFLAGS-1:0]      = f.flags;
    w[POS_I]           = f.i;
    w[POS_U]           = f.u;
    w[POS_PM]          = f.pm;
    w[IPL_MSB:IPL_LSB] = f.ipl;
    return w;
  endfunction

  function automatic psw_fields_t psw_unpack(input logic [WORD_W-1:0] w);
    psw_fields_t f;
    f.flags = w[NFLAGS-1:0];
    f.i     = w[POS_I];
    f.u     = w[POS_U];
    f.pm    = w[POS_PM];
    f.ipl   = w[IPL_MSB:IPL_LSB];
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] psw_live_mask();
    psw_fields_t ones;
    ones = '1;
    return psw_pack(ones);
  endfunction
endpackage

// File: rtl/psw_flag_reg.sv
module psw_flag_reg
  import psw_pkg::*;
#(
  parameter int N = NFLAGS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_wr,
  input  logic [N-1:0] flag_in,
  output logic [N-1:0] flag_q
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q[k] <= 1'b0;
      else if (flag_wr) flag_q[k] <= flag_in[k];
    end
  end

  AST_FLAGS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> flag_q == $past(flag_in)); // R2
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> $stable(flag_q)); // R9
endmodule

// File: rtl/psw_ctrl_reg.sv
module psw_ctrl_reg
  import psw_pkg::*;
#(
  parameter int LVL_W = IPL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_rti,
  input  logic             clr,
  input  logic [LVL_W-1:0] ipl_in,
  input  logic             pm_in,
  input  logic             u_in,
  input  logic             i_in,
  output logic [LVL_W-1:0] ipl_q,
  output logic             pm_q,
  output logic             u_q,
  output logic             i_q
);
  logic priv_wr;
  logic mode_wr;
  logic [LVL_W-1:0] ipl_d;
  logic pm_d, u_d, i_d;

  assign priv_wr = wr_en & ~pm_q;
  assign mode_wr = priv_wr & wr_rti;

  always_comb begin
    ipl_d = ipl_q;
    pm_d  = pm_q;
    u_d   = u_q;
    i_d   = i_q;
    if (priv_wr) begin
      ipl_d = ipl_in;
      u_d   = u_in;
      i_d   = i_in;
    end
    if (mode_wr) pm_d = pm_in;
    if (clr) begin
      pm_d = 1'b0;
      u_d  = 1'b0;
      i_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipl_q <= '0;
      pm_q  <= 1'b0;
      u_q   <= 1'b0;
      i_q   <= 1'b0;
    end else begin
      ipl_q <= ipl_d;
      pm_q  <= pm_d;
      u_q   <= u_d;
      i_q   <= i_d;
    end
  end

  AST_SUP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_wr && !clr) |=> (ipl_q == $past(ipl_in) && u_q == $past(u_in) && i_q == $past(i_in))); // R3
  AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pm_q && !clr) |=> ($stable(ipl_q) && $stable(u_q) && $stable(i_q) && pm_q)); // R4
  AST_MODE_RISE_RTI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pm_q) |-> $past(wr_en && wr_rti && !clr)); // R5
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pm_q && !u_q && !i_q)); // R6
  AST_CLR_KEEP_IPL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_en) |=> $stable(ipl_q)); // R6
  AST_CLR_BEATS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && wr_en) |=> (!pm_q && !u_q && !i_q)); // R7
endmodule

// File: rtl/psw_status_reg.sv
module psw_status_reg
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_rti,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              entry_clr,
  output logic [WORD_W-1:0] psw_word,
  output logic [IPL_W-1:0]  cur_ipl,
  output logic              user_mode,
  output logic              int_en,
  output logic              stack_sel
);
  localparam logic [WORD_W-1:0] LIVE = psw_live_mask();

  psw_fields_t wr_f;
  psw_fields_t cur_f;
  logic        unused_rsvd;

  assign wr_f        = psw_unpack(wr_data);
  assign unused_rsvd = ^(wr_data & ~LIVE);

  psw_flag_reg #(.N(NFLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag_wr (wr_en),
    .flag_in (wr_f.flags),
    .flag_q  (cur_f.flags)
  );

  psw_ctrl_reg #(.LVL_W(IPL_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_rti (wr_rti),
    .clr    (entry_clr),
    .ipl_in (wr_f.ipl),
    .pm_in  (wr_f.pm),
    .u_in   (wr_f.u),
    .i_in   (wr_f.i),
    .ipl_q  (cur_f.ipl),
    .pm_q   (cur_f.pm),
    .u_q    (cur_f.u),
    .i_q    (cur_f.i)
  );

  assign psw_word  = psw_pack(cur_f);
  assign cur_ipl   = cur_f.ipl;
  assign user_mode = cur_f.pm;
  assign int_en    = cur_f.i;
  assign stack_sel = cur_f.u;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_word & ~LIVE) == '0); // R8
  AST_PLAIN_WR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_rti && !entry_clr) |=> $stable(user_mode)); // R5
endmodule

// File: tb/psw_status_reg_tb.sv
module psw_status_reg_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [31:0] word;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_rti = 1'b0;
  logic [31:0] wr_data = '0;
  logic        entry_clr = 1'b0;
  logic [31:0] psw_word;
  logic [3:0]  cur_ipl;
  logic        user_mode, int_en, stack_sel;

  exp_t        sb[$];
  logic [31:0] model = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rti(wr_rti),
    .wr_data(wr_data), .entry_clr(entry_clr), .psw_word(psw_word),
    .cur_ipl(cur_ipl), .user_mode(user_mode), .int_en(int_en),
    .stack_sel(stack_sel)
  );

  // Independent model: mask arithmetic on whole words.
  function automatic logic [31:0] next_word(logic [31:0] old, bit we, bit rti,
                                            bit clr, logic [31:0] d);
    logic [31:0] n;
    n = old;
    if (we) n = (n & ~32'h0000_000F) | (d & 32'h0000_000F);
    if (we && old[20] == 1'b0) begin
      n = (n & ~32'h0F03_0000) | (d & 32'h0F03_0000);
      if (rti) n = (n & ~32'h0010_0000) | (d & 32'h0010_0000);
    end
    if (clr) n = n & ~32'h0013_0000;
    return n;
  endfunction

  task automatic drive(bit we, bit rti, bit clr, logic [31:0] d, string tag);
    @(negedge clk);
    wr_en = we; wr_rti = rti; entry_clr = clr; wr_data = d;
    @(posedge clk);
    model = next_word(model, we, rti, clr, d);
    sb.push_back('{word: model, tag: tag});
    @(negedge clk);
    wr_en = 0; wr_rti = 0; entry_clr = 0; wr_data = '0;
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (psw_word !== e.word) begin
        n_bad++;
        $display("FAIL %s word actual=%h expected=%h", e.tag, psw_word, e.word);
      end
      n_chk++;
      if ({cur_ipl, user_mode, int_en, stack_sel} !==
          {e.word[27:24], e.word[20], e.word[16], e.word[17]}) begin
        n_bad++;
        $display("FAIL %s fields actual=%h expected=%h", e.tag,
                 {cur_ipl, user_mode, int_en, stack_sel},
                 {e.word[27:24], e.word[20], e.word[16], e.word[17]});
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    sb.push_back('{word: 32'h0, tag: "R1 reset"});
    @(negedge clk);
    drive(1, 0, 0, 32'hFFFF_FFFF, "R2 R3 R8 supervisor write");
    drive(1, 1, 0, 32'h0A13_0005, "R5 rti enters user");
    drive(1, 0, 0, 32'hFFFF_FFFF, "R4 user write flags only");
    drive(1, 1, 0, 32'h0000_0000, "R4 R5 user rti ignored");
    drive(0, 0, 0, 32'hFFFF_FFFF, "R9 idle hold");
    drive(0, 0, 1, 32'h0000_0000, "R6 clear keeps ipl flags");
    drive(1, 0, 1, 32'h0503_0009, "R7 write with clear");
    drive(1, 1, 0, 32'h0B13_0003, "R5 rti to user again");
    drive(1, 1, 1, 32'h0713_000C, "R7 user write with clear");
    drive(1, 1, 1, 32'h0110_0000, "R7 rti with clear");
    drive(1, 0, 0, 32'h0013_0006, "R5 plain write keeps mode");
    drive(0, 0, 0, 32'h0000_0000, "R9 idle final");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule